// File: doc/BRIEF.md
# Descriptor-Chained Receive DMA Writer

This block is the receive side of a descriptor-driven DMA channel. A client offers a byte stream on a valid/ready port, each byte optionally tagged as the last byte of a packet. The engine fetches a four-word data descriptor from memory and stores incoming bytes into that descriptor's buffer window. It packs them into 32-bit little-endian words and writes partial words with byte enables.

A descriptor closes when its window is full or when a packet ends, whichever comes first. On close the engine writes the true fill point back into the descriptor's end field and records packet termination in its flags word. It also sets sticky raw interrupt bits. It then follows the descriptor's link to the next one, or, if the descriptor is flagged as the last in the list, marks the channel context disabled in memory and halts. Once halted it refuses all input until it is started again.

Descriptor layout, byte offsets from its base: +0 link to next descriptor, +4 buffer start, +8 flags (bit 0 last-in-list, bit 4 interrupt request, bit 11 closed-by-packet-end, written by the engine), +12 buffer end (exclusive). The context word at context base +4 carries a disabled flag in bit 15.

Top module: `rxd_writer`

## Requirements
- R1: A one-cycle `start_i` pulse in idle or halted state latches the descriptor and context addresses and reads the four descriptor words in order. `in_ready_o` is low whenever a memory request is outstanding. A request is held with a stable address until `mem_ack_i`.
- R2: An accepted byte is written at the current buffer pointer in byte lane `ptr[1:0]` (bits 7:0 = lane 0) of the word at `ptr & ~3`. A word write is issued when the pointer crosses a word boundary or the descriptor closes. Only the lanes filled since the previous write are enabled.
- R3: A descriptor whose pointer reaches its end field closes. The end field is rewritten with that same value, and flags bit 11 is written as 0.
- R4: A byte with `in_eop_i` set closes the descriptor early. The end field (+12) is rewritten with the address just past that byte, and flags bit 11 is set to 1.
- R5: On close, a descriptor with flags bit 4 set sets raw interrupt bits 0 and 1. A close caused by packet end sets raw bit 3.
- R6: Raw interrupt bits stay set until cleared by the matching bit of `irq_ack_i`. `irq_o` is high exactly when a raw bit and its `irq_mask_i` bit are both 1.
- R7: After closing a descriptor whose flags bit 0 is clear, the engine fetches the descriptor at the link field and restarts the buffer pointer at that descriptor's buffer start.
- R8: After closing a descriptor whose flags bit 0 is set, the engine writes bit 15 of the context word at context base +4 (byte enable 4'b0010), then raises `eol_o` and halts.
- R9: While `eol_o` is high, `in_ready_o` stays low and offered bytes are not written to memory.
- R10: A descriptor fetched with buffer start equal to buffer end closes at once without accepting a byte, with the same writeback and interrupt effects as R3 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse |
| desc_addr_i | input | 32 | First descriptor address |
| ctx_addr_i | input | 32 | Channel context address |
| in_valid_i | input | 1 | Client byte valid |
| in_data_i | input | 8 | Client byte |
| in_eop_i | input | 1 | Byte ends a packet |
| in_ready_o | output | 1 | Engine accepts a byte |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_be_o | output | 4 | Write byte enables |
| mem_ack_i | input | 1 | Request completed (read data valid) |
| mem_rdata_i | input | 32 | Read data |
| irq_mask_i | input | 4 | Interrupt mask |
| irq_ack_i | input | 4 | Clear pulse per raw bit |
| irq_raw_o | output | 4 | Sticky raw interrupt bits |
| irq_o | output | 1 | Masked interrupt line |
| eol_o | output | 1 | Halted at end of list |

## Verification
The hardest state to reach is a close that coincides with other events: a window that starts unaligned and ends on a packet mark in the next word, and a zero-length descriptor that must close without any byte arriving. The bench builds a descriptor chain in its memory model with an unaligned start followed by an early packet end. It also builds a second chain that starts with an empty window. It then compares every written word, including untouched neighbour bytes, against values derived from the descriptor layout.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
    localparam int ADDR_W = 32;
    localparam int LANES  = 4;
    localparam int WORD_W = 8 * LANES;
    localparam int LW     = $clog2(LANES);
    localparam int IRQ_N  = 4;

    // descriptor word offsets
    localparam int OFF_NEXT  = 0;
    localparam int OFF_START = 4;
    localparam int OFF_FLAGS = 8;
    localparam int OFF_END   = 12;
    localparam int OFF_CTXFL = 4;

    // flag bit positions
    localparam int FL_LAST  = 0;
    localparam int FL_IRQ   = 4;
    localparam int FL_PKEND = 11;
    localparam int CTX_OFF  = 15;

    // raw interrupt bits
    localparam int IRQ_D0  = 0;
    localparam int IRQ_D1  = 1;
    localparam int IRQ_PKT = 3;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_RUN, S_FLUSH, S_WB_END, S_WB_FLAG, S_CTX, S_HALT
    } rxd_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] next;
        logic [ADDR_W-1:0] start;
        logic [ADDR_W-1:0] stop;
        logic              last;
        logic              irq_req;
    } rxd_desc_t;

    function automatic logic [IRQ_N-1:0] close_bits(input logic irq_req, input logic pkt);
        logic [IRQ_N-1:0] v;
        v = '0;
        v[IRQ_D0]  = irq_req;
        v[IRQ_D1]  = irq_req;
        v[IRQ_PKT] = pkt;
        return v;
    endfunction
endpackage

// File: rtl/rxd_packer.sv
module rxd_packer #(
    parameter int LANES = 4,
    localparam int LW = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [LW-1:0]      lane,
    input  logic [7:0]         data_byte,
    input  logic               clr,
    output logic [8*LANES-1:0] word,
    output logic [LANES-1:0]   be
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                be[g]          <= 1'b0;
                word[8*g +: 8] <= 8'h00;
            end else if (wr_en && lane == LW'(g)) begin
                be[g]          <= 1'b1;
                word[8*g +: 8] <= data_byte;
            end
        end
    end
endmodule

// File: rtl/rxd_irq.sv
module rxd_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] ack,
    input  logic [N-1:0] mask,
    output logic [N-1:0] raw,
    output logic         line
);
    always_ff @(posedge clk) begin
        if (rst) raw <= '0;
        else     raw <= (raw & ~ack) | set;
    end

    assign line = |(raw & mask);
endmodule

// File: rtl/rxd_writer.sv
module rxd_writer
    import rxd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] desc_addr_i,
    input  logic [ADDR_W-1:0] ctx_addr_i,
    input  logic              in_valid_i,
    input  logic [7:0]        in_data_i,
    input  logic              in_eop_i,
    output logic              in_ready_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    output logic [LANES-1:0]  mem_be_o,
    input  logic              mem_ack_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    input  logic [IRQ_N-1:0]  irq_mask_i,
    input  logic [IRQ_N-1:0]  irq_ack_i,
    output logic [IRQ_N-1:0]  irq_raw_o,
    output logic              irq_o,
    output logic              eol_o
);
    rxd_state_e        state;
    rxd_desc_t         desc;
    logic [1:0]        fidx;
    logic [ADDR_W-1:0] desc_base, ctx_base, ptr, flush_addr;
    logic              close_pend, pkt_pend, eol_q;

    logic              accept, nxt_wrap, nxt_hit, empty_win, close_fire;
    logic [ADDR_W-1:0] nxt_ptr;
    logic [WORD_W-1:0] pk_word;
    logic [LANES-1:0]  pk_be;
    logic [IRQ_N-1:0]  irq_set;

    assign in_ready_o = (state == S_RUN);
    assign accept     = in_ready_o && in_valid_i;
    assign nxt_ptr    = ptr + ADDR_W'(1);
    assign nxt_wrap   = (nxt_ptr[LW-1:0] == '0);
    assign nxt_hit    = (nxt_ptr == desc.stop);
    assign empty_win  = (state == S_FETCH) && mem_ack_i && (fidx == 2'd3)
                        && (desc.start == mem_rdata_i);
    assign close_fire = empty_win || ((state == S_FLUSH) && mem_ack_i && close_pend);
    assign irq_set    = close_fire ? close_bits(desc.irq_req, (state == S_FLUSH) && pkt_pend)
                                   : '0;
    assign eol_o      = eol_q;

    rxd_packer #(.LANES(LANES)) u_pack (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (accept),
        .lane      (ptr[LW-1:0]),
        .data_byte (in_data_i),
        .clr       ((state == S_FLUSH) && mem_ack_i),
        .word      (pk_word),
        .be        (pk_be)
    );

    rxd_irq #(.N(IRQ_N)) u_irq (
        .clk  (clk),
        .rst  (rst),
        .set  (irq_set),
        .ack  (irq_ack_i),
        .mask (irq_mask_i),
        .raw  (irq_raw_o),
        .line (irq_o)
    );

    // memory request decode
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        mem_be_o    = '0;
        unique case (state)
            S_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = desc_base + ADDR_W'({fidx, 2'b00});
            end
            S_FLUSH: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = flush_addr;
                mem_wdata_o = pk_word;
                mem_be_o    = pk_be;
            end
            S_WB_END: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = desc_base + ADDR_W'(OFF_END);
                mem_wdata_o = ptr;
                mem_be_o    = '1;
            end
            S_WB_FLAG: begin
                mem_req_o             = 1'b1;
                mem_we_o              = 1'b1;
                mem_addr_o            = desc_base + ADDR_W'(OFF_FLAGS);
                mem_wdata_o[FL_PKEND] = pkt_pend;
                mem_be_o              = LANES'(1) << (FL_PKEND / 8);
            end
            S_CTX: begin
                mem_req_o            = 1'b1;
                mem_we_o             = 1'b1;
                mem_addr_o           = ctx_base + ADDR_W'(OFF_CTXFL);
                mem_wdata_o[CTX_OFF] = 1'b1;
                mem_be_o             = LANES'(1) << (CTX_OFF / 8);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            desc       <= '0;
            fidx       <= '0;
            desc_base  <= '0;
            ctx_base   <= '0;
            ptr        <= '0;
            flush_addr <= '0;
            close_pend <= 1'b0;
            pkt_pend   <= 1'b0;
            eol_q      <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE, S_HALT: if (start_i) begin
                    desc_base  <= desc_addr_i;
                    ctx_base   <= ctx_addr_i;
                    eol_q      <= 1'b0;
                    fidx       <= '0;
                    close_pend <= 1'b0;
                    pkt_pend   <= 1'b0;
                    state      <= S_FETCH;
                end
                S_FETCH: if (mem_ack_i) begin
                    fidx <= fidx + 2'd1;
                    unique case (fidx)
                        2'd0: desc.next  <= mem_rdata_i;
                        2'd1: desc.start <= mem_rdata_i;
                        2'd2: begin
                            desc.last    <= mem_rdata_i[FL_LAST];
                            desc.irq_req <= mem_rdata_i[FL_IRQ];
                        end
                        default: begin
                            desc.stop <= mem_rdata_i;
                            ptr       <= desc.start;
                            state     <= empty_win ? S_WB_END : S_RUN;
                        end
                    endcase
                end
                S_RUN: if (accept) begin
                    ptr <= nxt_ptr;
                    if (nxt_wrap || nxt_hit || in_eop_i) begin
                        flush_addr <= {ptr[ADDR_W-1:LW], LW'(0)};
                        close_pend <= nxt_hit || in_eop_i;
                        pkt_pend   <= in_eop_i;
                        state      <= S_FLUSH;
                    end
                end
                S_FLUSH: if (mem_ack_i) state <= close_pend ? S_WB_END : S_RUN;
                S_WB_END: if (mem_ack_i) state <= S_WB_FLAG;
                S_WB_FLAG: if (mem_ack_i) begin
                    close_pend <= 1'b0;
                    pkt_pend   <= 1'b0;
                    if (desc.last) begin
                        state <= S_CTX;
                    end else begin
                        desc_base <= desc.next;
                        fidx      <= '0;
                        state     <= S_FETCH;
                    end
                end
                S_CTX: if (mem_ack_i) begin
                    eol_q <= 1'b1;
                    state <= S_HALT;
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rxd_writer_chk.sv
module rxd_writer_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_ready_o,
    input logic        mem_req_o,
    input logic        mem_we_o,
    input logic [31:0] mem_addr_o,
    input logic [3:0]  mem_be_o,
    input logic        mem_ack_i,
    input logic [3:0]  irq_ack_i,
    input logic [3:0]  irq_raw_o,
    input logic        eol_o
);
    assert_ready_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        in_ready_o |-> !mem_req_o);

    assert_req_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

    assert_write_enables_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && mem_we_o) |-> (mem_be_o != 4'b0000));

    assert_raw_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        ((irq_raw_o & ~irq_ack_i) != 4'b0000)
        |=> ((irq_raw_o & $past(irq_raw_o & ~irq_ack_i)) == $past(irq_raw_o & ~irq_ack_i)));

    assert_ctx_last_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(eol_o) |-> $past(mem_req_o && mem_we_o && mem_ack_i && mem_be_o == 4'b0010));

    assert_refuse_R9: assert property (@(posedge clk) disable iff (rst)
        eol_o |-> !in_ready_o);
endmodule

bind rxd_writer rxd_writer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_ready_o (in_ready_o),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_be_o   (mem_be_o),
    .mem_ack_i  (mem_ack_i),
    .irq_ack_i  (irq_ack_i),
    .irq_raw_o  (irq_raw_o),
    .eol_o      (eol_o)
);

// File: tb/rxd_writer_tb.sv
`timescale 1ns/1ps
module rxd_writer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] desc_addr_i = '0, ctx_addr_i = '0;
    logic        in_valid_i = 1'b0, in_eop_i = 1'b0;
    logic [7:0]  in_data_i = '0;
    logic        in_ready_o, mem_req_o, mem_we_o, mem_ack_i, irq_o, eol_o;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic [3:0]  mem_be_o, irq_raw_o;
    logic [3:0]  irq_mask_i = '0, irq_ack_i = '0;

    int n_chk = 0, n_bad = 0;
    logic [31:0] mem [0:255];

    always #2.5 clk = ~clk;

    rxd_writer u_dut (.*);

    // memory model: one-cycle ack, read data with ack
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_ack_i   <= 1'b0;
            mem_rdata_i <= '0;
        end else begin
            mem_ack_i <= mem_req_o && !mem_ack_i;
            if (mem_req_o && !mem_ack_i) begin
                if (mem_we_o) begin
                    for (int b = 0; b < 4; b++)
                        if (mem_be_o[b]) mem[mem_addr_o[9:2]][8*b +: 8] <= mem_wdata_o[8*b +: 8];
                end else begin
                    mem_rdata_i <= mem[mem_addr_o[9:2]];
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put_desc(input logic [31:0] base, input logic [31:0] nxt,
                            input logic [31:0] st, input logic [31:0] fl, input logic [31:0] en);
        mem[base[9:2]]     = nxt;
        mem[base[9:2] + 1] = st;
        mem[base[9:2] + 2] = fl;
        mem[base[9:2] + 3] = en;
    endtask

    task automatic kick(input logic [31:0] d, input logic [31:0] c);
        @(negedge clk);
        start_i = 1'b1; desc_addr_i = d; ctx_addr_i = c;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, input logic e);
        in_valid_i = 1'b1; in_data_i = d; in_eop_i = e;
        while (!in_ready_o) @(negedge clk);
        @(negedge clk);
        in_valid_i = 1'b0; in_eop_i = 1'b0;
    endtask

    task automatic wait_halt();
        int t = 0;
        while (!eol_o && t < 2000) begin @(negedge clk); t++; end
        if (!eol_o) chk("R8 halt reached", 32'd0, 32'd1);
    endtask

    task automatic t_reset();
        chk("R1 reset ready", {31'd0, in_ready_o}, 32'd0);
        chk("R1 reset req", {31'd0, mem_req_o}, 32'd0);
        chk("R6 reset irq", {27'd0, irq_raw_o, irq_o}, 32'd0);
        chk("R8 reset eol", {31'd0, eol_o}, 32'd0);
    endtask

    // unaligned chain, full close then early packet end
    task automatic t_chain();
        put_desc(32'h000, 32'h010, 32'h100, 32'h10, 32'h106);
        put_desc(32'h010, 32'h000, 32'h202, 32'h01, 32'h20A);
        kick(32'h000, 32'h040);
        chk("R1 fetch holds ready low", {30'd0, in_ready_o, mem_req_o}, 32'd1);
        for (int i = 0; i < 6; i++) send(8'h11 + 8'(i), 1'b0);
        send(8'h21, 1'b0); send(8'h22, 1'b0); send(8'h23, 1'b1);
        wait_halt();
        chk("R2 full word", mem[8'h40], 32'h14131211);
        chk("R2 partial word", mem[8'h41], 32'hEEEE1615);
        chk("R3 end kept", mem[8'h03], 32'h106);
        chk("R3 flag clear", mem[8'h02], 32'h10);
        chk("R2 R7 unaligned start", mem[8'h80], 32'h2221EEEE);
        chk("R4 eop word", mem[8'h81], 32'hEEEEEE23);
        chk("R4 end rewritten", mem[8'h07], 32'h205);
        chk("R4 pkt flag", mem[8'h06], 32'h801);
        chk("R5 raw bits", {28'd0, irq_raw_o}, 32'hB);
        chk("R8 ctx disabled", mem[8'h11], 32'h8000);
        chk("R8 eol", {31'd0, eol_o}, 32'd1);
        irq_mask_i = 4'h8; #0.1;
        chk("R6 masked line on", {31'd0, irq_o}, 32'd1);
        irq_mask_i = 4'h4; #0.1;
        chk("R6 masked line off", {31'd0, irq_o}, 32'd0);
        irq_mask_i = 4'hF;
        @(negedge clk); irq_ack_i = 4'hF;
        @(negedge clk); irq_ack_i = 4'h0;
        chk("R6 ack clears", {27'd0, irq_raw_o, irq_o}, 32'd0);
    endtask

    task automatic t_refuse();
        in_valid_i = 1'b1; in_data_i = 8'h99; in_eop_i = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R9 ready low", {31'd0, in_ready_o}, 32'd0);
        end
        in_valid_i = 1'b0; in_eop_i = 1'b0;
        chk("R9 memory untouched", mem[8'h81], 32'hEEEEEE23);
        chk("R9 no new irq", {28'd0, irq_raw_o}, 32'd0);
    endtask

    // empty window then exact fill
    task automatic t_empty();
        put_desc(32'h020, 32'h030, 32'h300, 32'h10, 32'h300);
        put_desc(32'h030, 32'h000, 32'h308, 32'h01, 32'h30C);
        kick(32'h020, 32'h050);
        for (int i = 0; i < 4; i++) send(8'h31 + 8'(i), 1'b0);
        wait_halt();
        chk("R10 no bytes", mem[8'hC0], 32'hEEEEEEEE);
        chk("R10 end kept", mem[8'h0B], 32'h300);
        chk("R10 R5 raw", {28'd0, irq_raw_o}, 32'h3);
        chk("R2 R7 exact word", mem[8'hC2], 32'h34333231);
        chk("R3 end kept", mem[8'h0F], 32'h30C);
        chk("R3 flag clear", mem[8'h0E], 32'h1);
        chk("R8 ctx disabled", mem[8'h15], 32'h8000);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hEEEEEEEE;
        mem[8'h11] = '0; mem[8'h15] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_chain();
        t_refuse();
        t_empty();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule